// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Responder

This block is the device side of a serial flash that answers two wide fast-read commands. The host lowers chip-select and sends an 8-bit command one bit per serial clock on lane 0. Command BBh switches the rest of the transaction to two lanes. Command EBh switches it to four lanes. The address, the dummy clocks and the returned data all then use the selected lane count.

Data comes from an internal byte array. A backdoor write port fills this array before reads. The array is not reset. A read may start at any byte. It then streams consecutive bytes for as long as chip-select stays low, and wraps from the last byte of the array to byte zero.

The block runs on a fast system clock and oversamples the serial clock. A rising serial-clock edge samples the inputs. A falling edge updates the outputs. Raising chip-select abandons the transaction at once, whatever phase it is in.

Top module: `mio_read_responder`

## Requirements
- R1: The command byte is sampled from dq_in[0] on 8 rising serial-clock edges, most significant bit first. Value 8'hBB selects two-lane mode and 8'hEB selects four-lane mode.
- R2: The address is 24 bits, most significant first. In two-lane mode it takes 12 rising edges, with the higher bit of each pair on dq_in[1]. In four-lane mode it takes 6 rising edges, with the highest bit of each group on dq_in[3]. Only the low log2(MEM_BYTES) address bits select a byte.
- R3: After the address, the block waits DUAL_DUMMY rising edges (default 4) in two-lane mode, or QUAD_DUMMY rising edges (default 6) in four-lane mode. Data begins on the falling edge that follows the last of these edges.
- R4: Data is driven on falling serial-clock edges, most significant bits first. In two-lane mode, bits 7 and 6 appear on dq_out[1] and dq_out[0], then bits 5 and 4, and so on. In four-lane mode, bits 7..4 appear on dq_out[3:0], then bits 3..0. Unused lanes read 0.
- R5: dq_oe is 4'b0000 through the command, address and dummy phases. From the first data falling edge it is 4'b0011 in two-lane mode and 4'b1111 in four-lane mode. dq_oe and dq_out change only on a falling serial-clock edge, on chip-select going high, or on reset.
- R6: After each complete byte, the read address advances by one. Bytes keep streaming while chip-select stays low.
- R7: After byte MEM_BYTES-1, the stream continues from byte 0.
- R8: A read may start at any byte address, odd or even, with no alignment.
- R9: Once chip-select is high, by the next system clock dq_oe and dq_out are 0 and the block is waiting for a new command. This holds in any phase, including a clock in which a data falling edge also occurs.
- R10: After any other command value, dq_oe stays 0 for every further serial clock until chip-select rises.
- R11: A synchronous active-high reset clears dq_oe and dq_out to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial interface |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip-select |
| sck | input | 1 | Serial clock from the host |
| dq_in | input | 4 | Input values of the four data lanes |
| dq_out | output | 4 | Output values of the four data lanes |
| dq_oe | output | 4 | Per-lane output enables |
| bd_we | input | 1 | Backdoor write strobe for the byte array |
| bd_addr | input | $clog2(MEM_BYTES) | Backdoor write address |
| bd_wdata | input | 8 | Backdoor write data |

## Verification
Two events can land on the same system-clock edge: the final slice of a byte, with its address increment and possible wrap to zero, and a falling data edge that meets chip-select going high. The bench provokes the first by starting reads on the last bytes of the array, so that the increment and the wrap share one falling edge. It provokes the second by lowering the serial clock and raising chip-select on the same clock, in the middle of a data phase. The scoreboard compares every rising edge against the bytes a bench model predicts. A direct check after the collision expects released enables and zeroed lanes. A fresh read must then behave normally.

// File: rtl/mio_pkg.sv
package mio_pkg;

    localparam int ADDR_BITS = 24;
    localparam logic [7:0] OP_READ_X2 = 8'hBB;
    localparam logic [7:0] OP_READ_X4 = 8'hEB;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WAIT,
        PH_DATA,
        PH_IDLE_SEL
    } phase_e;

    typedef enum logic {
        LANES2,
        LANES4
    } width_e;

    typedef struct packed {
        phase_e     phase;
        width_e     width;
        logic [7:0] cnt;
    } ctl_t;

    function automatic int addr_clocks(width_e w);
        return (w == LANES4) ? ADDR_BITS / 4 : ADDR_BITS / 2;
    endfunction

    function automatic logic [3:0] lane_mask(width_e w);
        return (w == LANES4) ? 4'b1111 : 4'b0011;
    endfunction

    function automatic logic [3:0] pick_slice(logic [7:0] b, width_e w, logic [1:0] idx);
        logic [3:0] r;
        if (w == LANES4) begin
            r = idx[0] ? b[3:0] : b[7:4];
        end else begin
            case (idx)
                2'd0:    r = {2'b00, b[7:6]};
                2'd1:    r = {2'b00, b[5:4]};
                2'd2:    r = {2'b00, b[3:2]};
                default: r = {2'b00, b[1:0]};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/mio_sck_edge.sv
module mio_sck_edge (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    output logic rise,
    output logic fall
);
    logic sck_q;

    always_ff @(posedge clk) begin
        if (rst) sck_q <= 1'b0;
        else     sck_q <= sck;
    end

    assign rise = sck & ~sck_q;
    assign fall = ~sck & sck_q;
endmodule

// File: rtl/mio_byte_store.sv
module mio_byte_store #(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_addr] <= wr_data;
    end

    assign rd_data = cells[rd_addr];
endmodule

// File: rtl/mio_serializer.sv
module mio_serializer
    import mio_pkg::*;
(
    input  logic [7:0] byte_in,
    input  width_e     width,
    input  logic [1:0] idx,
    output logic [3:0] lanes,
    output logic [3:0] mask
);
    always_comb begin
        lanes = pick_slice(byte_in, width, idx);
        mask  = lane_mask(width);
    end
endmodule

// File: rtl/mio_read_responder.sv
module mio_read_responder
    import mio_pkg::*;
#(
    parameter int MEM_BYTES  = 256,
    parameter int DUAL_DUMMY = 4,
    parameter int QUAD_DUMMY = 6
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cs_n,
    input  logic                         sck,
    input  logic [3:0]                   dq_in,
    output logic [3:0]                   dq_out,
    output logic [3:0]                   dq_oe,
    input  logic                         bd_we,
    input  logic [$clog2(MEM_BYTES)-1:0] bd_addr,
    input  logic [7:0]                   bd_wdata
);
    localparam int AW = $clog2(MEM_BYTES);
    localparam int CW = 8;
    localparam logic [AW-1:0] TOP_ADDR = AW'(MEM_BYTES - 1);

    ctl_t                 ctl;
    logic [7:0]           op_sr;
    logic [ADDR_BITS-1:0] addr_sr;
    logic [AW-1:0]        rd_ptr;
    logic [1:0]           slice;

    logic                 rise, fall;
    logic [7:0]           op_next;
    logic [ADDR_BITS-1:0] addr_next;
    logic [CW-1:0]        addr_last, wait_last;
    logic [1:0]           slice_last;
    logic [AW-1:0]        ptr_next;
    logic [7:0]           rd_byte;
    logic [3:0]           ser_lanes, ser_mask;

    mio_sck_edge u_edge (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .rise (rise),
        .fall (fall)
    );

    mio_byte_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (bd_we),
        .wr_addr (bd_addr),
        .wr_data (bd_wdata),
        .rd_addr (rd_ptr),
        .rd_data (rd_byte)
    );

    mio_serializer u_ser (
        .byte_in (rd_byte),
        .width   (ctl.width),
        .idx     (slice),
        .lanes   (ser_lanes),
        .mask    (ser_mask)
    );

    always_comb begin
        op_next    = {op_sr[6:0], dq_in[0]};
        addr_next  = (ctl.width == LANES4) ? {addr_sr[ADDR_BITS-5:0], dq_in}
                                           : {addr_sr[ADDR_BITS-3:0], dq_in[1:0]};
        addr_last  = CW'(addr_clocks(ctl.width) - 1);
        wait_last  = (ctl.width == LANES4) ? CW'(QUAD_DUMMY - 1) : CW'(DUAL_DUMMY - 1);
        slice_last = (ctl.width == LANES4) ? 2'd1 : 2'd3;
        ptr_next   = (rd_ptr == TOP_ADDR) ? '0 : rd_ptr + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '{phase: PH_CMD, width: LANES2, cnt: '0};
            op_sr   <= '0;
            addr_sr <= '0;
            rd_ptr  <= '0;
            slice   <= '0;
            dq_out  <= '0;
            dq_oe   <= '0;
        end else if (cs_n) begin
            ctl.phase <= PH_CMD;
            ctl.cnt   <= '0;
            slice     <= '0;
            dq_out    <= '0;
            dq_oe     <= '0;
        end else begin
            case (ctl.phase)
                PH_CMD: if (rise) begin
                    op_sr <= op_next;
                    if (ctl.cnt == CW'(7)) begin
                        ctl.cnt <= '0;
                        if (op_next == OP_READ_X2) begin
                            ctl.phase <= PH_ADDR;
                            ctl.width <= LANES2;
                        end else if (op_next == OP_READ_X4) begin
                            ctl.phase <= PH_ADDR;
                            ctl.width <= LANES4;
                        end else begin
                            ctl.phase <= PH_IDLE_SEL;
                        end
                    end else begin
                        ctl.cnt <= ctl.cnt + 1'b1;
                    end
                end
                PH_ADDR: if (rise) begin
                    addr_sr <= addr_next;
                    if (ctl.cnt == addr_last) begin
                        rd_ptr    <= addr_next[AW-1:0];
                        ctl.cnt   <= '0;
                        ctl.phase <= PH_WAIT;
                    end else begin
                        ctl.cnt <= ctl.cnt + 1'b1;
                    end
                end
                PH_WAIT: if (rise) begin
                    if (ctl.cnt == wait_last) begin
                        ctl.cnt   <= '0;
                        ctl.phase <= PH_DATA;
                    end else begin
                        ctl.cnt <= ctl.cnt + 1'b1;
                    end
                end
                PH_DATA: if (fall) begin
                    dq_out <= ser_lanes;
                    dq_oe  <= ser_mask;
                    if (slice == slice_last) begin
                        slice  <= '0;
                        rd_ptr <= ptr_next;
                    end else begin
                        slice <= slice + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mio_read_checker.sv
module mio_read_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sck,
    input logic [3:0] dq_out,
    input logic [3:0] dq_oe
);
    logic sck_seen;
    logic fall_obs;

    always_ff @(posedge clk) begin
        if (rst) sck_seen <= 1'b0;
        else     sck_seen <= sck;
    end

    assign fall_obs = ~sck & sck_seen;

    assert_abort_release_R9: assert property (@(posedge clk) disable iff (rst)
        $past(cs_n) |-> (dq_oe == 4'h0 && dq_out == 4'h0));

    assert_lane_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (dq_oe == 4'h0 || dq_oe == 4'h3 || dq_oe == 4'hF));

    assert_out_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cs_n) && !$past(fall_obs)) |-> $stable(dq_out));

    assert_oe_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cs_n) && !$past(fall_obs)) |-> $stable(dq_oe));

    assert_unused_lanes_R4: assert property (@(posedge clk) disable iff (rst)
        (dq_oe == 4'h3) |-> (dq_out[3:2] == 2'b00));
endmodule

bind mio_read_responder mio_read_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .sck    (sck),
    .dq_out (dq_out),
    .dq_oe  (dq_oe)
);

// File: tb/tb_mio_read_responder.sv
module tb_mio_read_responder;
    localparam int MEMB = 256;
    localparam int DD   = 4;
    localparam int QD   = 6;

    logic       clk = 1'b0;
    logic       rst, cs_n, sck, bd_we;
    logic [3:0] dq_in, dq_out, dq_oe;
    logic [7:0] bd_addr, bd_wdata;

    always #5 clk = ~clk;

    mio_read_responder dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe),
        .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata)
    );

    typedef struct {
        logic [3:0] oe;
        logic [3:0] dat;
        string      tag;
    } exp_t;

    exp_t       sbq[$];
    int         n_cmp = 0;
    int         n_bad = 0;
    logic [7:0] model [MEMB];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: one expected item per rising serial edge while selected
    always @(posedge sck) begin
        exp_t e;
        if (cs_n === 1'b0) begin
            if (sbq.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL scoreboard: actual edge with no item expected %0d", 0);
            end else begin
                e = sbq.pop_front();
                chk(e.tag, {dq_oe, dq_out}, {e.oe, e.dat});
            end
        end
    end

    task automatic pulse(input logic [3:0] d, input logic [3:0] eoe,
                         input logic [3:0] edat, input string tag);
        sbq.push_back('{oe: eoe, dat: edat, tag: tag});
        dq_in = d;
        sck   = 1'b0;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic select_dev();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic deselect_dev(input string tag);
        cs_n = 1'b1;
        sck  = 1'b0;
        repeat (2) @(negedge clk);
        chk(tag, {dq_oe, dq_out}, 8'h00);
        chk({tag, " queue drained"}, 8'(sbq.size()), 8'h00);
    endtask

    task automatic send_cmd(input logic [7:0] op);
        for (int i = 0; i < 8; i++) pulse({3'b000, op[7-i]}, 4'h0, 4'h0, "R1 cmd oe low");
    endtask

    task automatic send_addr(input bit quad, input logic [23:0] a, input int limit);
        int n;
        n = quad ? 6 : 12;
        if (limit < n) n = limit;
        for (int k = 0; k < n; k++) begin
            if (quad) pulse(a[23-4*k -: 4], 4'h0, 4'h0, "R2 addr oe low");
            else      pulse({2'b00, a[23-2*k -: 2]}, 4'h0, 4'h0, "R2 addr oe low");
        end
    endtask

    task automatic send_data(input bit quad, input logic [23:0] a, input int nbytes);
        for (int b = 0; b < nbytes; b++) begin
            int         idx;
            logic [7:0] v;
            string      tg;
            idx = (int'(a % MEMB) + b) % MEMB;
            v   = model[idx];
            tg  = (b == 0) ? "R4 first byte" : ((idx == 0) ? "R7 wrap byte" : "R6 next byte");
            if (quad) begin
                pulse(4'h0, 4'hF, v[7:4], tg);
                pulse(4'h0, 4'hF, v[3:0], tg);
            end else begin
                for (int k = 0; k < 4; k++)
                    pulse(4'h0, 4'h3, {2'b00, v[7-2*k], v[6-2*k]}, tg);
            end
        end
    endtask

    task automatic read_txn(input bit quad, input logic [23:0] a, input int nbytes);
        select_dev();
        send_cmd(quad ? 8'hEB : 8'hBB);
        send_addr(quad, a, 99);
        for (int i = 0; i < (quad ? QD : DD); i++) pulse(4'h0, 4'h0, 4'h0, "R3,R5 dummy oe low");
        send_data(quad, a, nbytes);
        deselect_dev("R9 release after read");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; sck = 1'b0; dq_in = 4'h0;
        bd_we = 1'b0; bd_addr = '0; bd_wdata = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset state", {dq_oe, dq_out}, 8'h00);

        for (int i = 0; i < MEMB; i++) begin
            model[i] = 8'(i * 37 + 11);
            bd_we    = 1'b1;
            bd_addr  = 8'(i);
            bd_wdata = model[i];
            @(negedge clk);
        end
        bd_we = 1'b0;

        // R1 R2 R3 R4 R6: two-lane and four-lane streams
        read_txn(1'b0, 24'h000010, 5);
        read_txn(1'b1, 24'h0000A3, 4);
        // R7: wrap at the top in both modes
        read_txn(1'b0, 24'h0000FE, 4);
        read_txn(1'b1, 24'h0000FF, 3);
        // R8 and R2 upper bits ignored: odd, unaligned start
        read_txn(1'b1, 24'hABCD05, 2);
        read_txn(1'b0, 24'h123477, 3);

        // R10: unsupported command keeps lanes released
        select_dev();
        send_cmd(8'h03);
        for (int i = 0; i < 12; i++) pulse(4'hF, 4'h0, 4'h0, "R10 unsupported oe low");
        deselect_dev("R10 release");

        // R9: abort in the middle of the address
        select_dev();
        send_cmd(8'hBB);
        send_addr(1'b0, 24'h000040, 4);
        deselect_dev("R9 abort in address");
        read_txn(1'b1, 24'h000021, 2);

        // R9: chip-select rises in the same clock as a data falling edge
        select_dev();
        send_cmd(8'hEB);
        send_addr(1'b1, 24'h000030, 99);
        for (int i = 0; i < QD; i++) pulse(4'h0, 4'h0, 4'h0, "R3,R5 dummy oe low");
        send_data(1'b1, 24'h000030, 1);
        deselect_dev("R9 abort on data edge");
        read_txn(1'b0, 24'h000031, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule